// File: doc/BRIEF.md
# Deserializer Output State Controller

This block governs the parallel output stage of a serial-link receiver. That stage has a data bus (24 bits by default), three control lines and a clock output. The block decides, cycle by cycle, whether each group is driven, and whether it carries the received value, a forced low, a forced high, or a free-running fallback clock. It makes that choice from five inputs: a power-enable input, an asynchronous link-lock indicator, a mode strap, an output-state select and a 3-bit oscillator select.

The strap is captured when power is enabled. If it enables hold-low mode, every output except the lock indicator is driven low while the link is unlocked. The outputs stay low after lock returns, until software sends a release pulse through the register interface. A release pulse counts only while the link is locked. The hold re-arms by itself when lock falls, and software can also re-arm it by hand while locked. Without hold-low mode, an unlocked link leaves the outputs high-impedance or drives them high, as the output-state select chooses. A nonzero oscillator select switches the clock output to a free-running source. The nominal source frequencies are about 10 MHz for code 101, 8.3 MHz for 110 and 6.3 MHz for 111. The source itself is outside this block: the block only reports its select code.

Top module: `dser_out_ctrl`

## Requirements
- R1: While `pwr_on_i` is low, all three output enables are 0, `out_data_o` and `out_ctrl_o` are 0, `out_clk_src_o` is 2'b10 and `lock_o` is 0. This also holds during the first cycle after `pwr_on_i` rises, until the strap has been captured.
- R2: `hold_strap_i` is captured on the first rising clock edge that sees `pwr_on_i` high after it was low. Changes to the strap while power stays on have no effect until the next power-down.
- R3: With hold-low mode captured and the synchronized lock low, the data and control buses are driven (enables 1) with value 0, the clock is driven with source code 2'b10 (low), and `lock_o` is 0.
- R4: After lock returns in hold-low mode, the outputs stay held low until a `hold_release_i` pulse arrives while the synchronized lock is high. From then on the outputs pass through as in R12.
- R5: A `hold_release_i` pulse that arrives while the synchronized lock is low is dropped and not queued. The outputs stay held low after lock returns.
- R6: A falling edge of the synchronized lock re-arms the hold in hold-low mode. After lock returns, the outputs stay low until a new release pulse arrives.
- R7: A `hold_rearm_i` pulse while the synchronized lock is high re-arms the hold in hold-low mode. If a release pulse and a re-arm pulse arrive in the same cycle, the re-arm wins.
- R8: Without hold-low mode and with lock low: if `oss_high_i`=0, the data and control enables are 0 and the values are 0. If `oss_high_i`=1, the data and control buses are driven with all ones.
- R9: In hold-low mode, `oss_high_i` has no effect on any output.
- R10: Without hold-low mode and with lock low, a nonzero `osc_sel_i` gives `out_clk_oe_o`=1, `out_clk_src_o`=2'b01 and `osc_code_o`=`osc_sel_i`. A zero `osc_sel_i` gives either clock enable 0, or clock enable 1 with source 2'b11 (high), as `oss_high_i` selects. In every other state `osc_code_o` is 0.
- R11: `lock_async_i` passes through a two-flop synchronizer. A change made between clock edges appears on `lock_o` after the second following rising edge.
- R12: With power on, lock high and no hold active: `out_data_o`=`rx_data_i`, `out_ctrl_o`=`rx_ctrl_i`, all enables are 1 and `out_clk_src_o`=2'b00 (recovered clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pwr_on_i | input | 1 | Power enable; low means powered down |
| hold_strap_i | input | 1 | Latched strap value that selects hold-low mode |
| lock_async_i | input | 1 | Link-lock indicator, asynchronous |
| oss_high_i | input | 1 | Unlocked output state: 0 high-impedance, 1 drive high |
| osc_sel_i | input | 3 | Fallback oscillator select; 000 disables the oscillator |
| hold_rearm_i | input | 1 | Register pulse that re-arms the hold |
| hold_release_i | input | 1 | Register pulse that releases the hold |
| rx_data_i | input | 24 | Received parallel data |
| rx_ctrl_i | input | 3 | Received control bits |
| out_data_o | output | 24 | Data bus value |
| out_data_oe_o | output | 1 | Data bus drive enable |
| out_ctrl_o | output | 3 | Control output value |
| out_ctrl_oe_o | output | 1 | Control output drive enable |
| out_clk_oe_o | output | 1 | Clock output drive enable |
| out_clk_src_o | output | 2 | Clock source: 00 recovered, 01 oscillator, 10 low, 11 high |
| osc_code_o | output | 3 | Oscillator select in use, 0 when the oscillator is not in use |
| lock_o | output | 1 | Synchronized lock indicator |

## Verification
Two pairs of events can fall in the same cycle. A release pulse can coincide with a re-arm pulse. A release pulse can also arrive on the edge where the asynchronous lock input drops, so that the release is still accepted and the falling edge then re-arms the hold. The bench provokes both pairs in directed cases and within its random sequence. It judges the outcome at the ports after lock has settled again: the outputs must still be held low, and a later release alone must free them.

// File: rtl/dser_out_pkg.sv
package dser_out_pkg;
  typedef enum logic [1:0] {
    CLK_RECOV = 2'b00,
    CLK_OSC   = 2'b01,
    CLK_LOW   = 2'b10,
    CLK_HIGH  = 2'b11
  } clk_src_e;
endpackage

// File: rtl/dser_lock_sync.sv
module dser_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  output logic lk_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = lock_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], lock_i};
    end
  endgenerate

  always_comb prev_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign lk_o   = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

  // R6: a reported fall always follows a cycle of synchronized lock high
  p_fall_after_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> (!lk_o && $past(lk_o)));
endmodule

// File: rtl/dser_strap_cap.sv
module dser_strap_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on_i,
  input  logic strap_i,
  output logic powered_o,
  output logic rise_o,
  output logic mode_en_o
);
  logic pwr_q, pwr_d;
  logic mode_q, mode_d;

  always_comb begin
    pwr_d  = pwr_on_i;
    mode_d = mode_q;
    if (!pwr_on_i)          mode_d = 1'b0;
    else if (!pwr_q)        mode_d = strap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      pwr_q  <= pwr_d;
      mode_q <= mode_d;
    end
  end

  assign rise_o    = pwr_on_i & ~pwr_q;
  assign powered_o = pwr_on_i & pwr_q;
  assign mode_en_o = mode_q;

  // R2: once captured, the mode stays put while power stays on
  p_strap_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on_i && pwr_q) |=> $stable(mode_en_o));
endmodule

// File: rtl/dser_hold_latch.sv
module dser_hold_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on_i,
  input  logic pwr_rise_i,
  input  logic strap_i,
  input  logic mode_en_i,
  input  logic lk_i,
  input  logic fall_i,
  input  logic rearm_i,
  input  logic release_i,
  output logic hold_active_o
);
  logic held_q, held_d;

  always_comb begin
    held_d = held_q;
    if (!pwr_on_i)                held_d = 1'b0;
    else if (pwr_rise_i)          held_d = strap_i;
    else if (!mode_en_i)          held_d = 1'b0;
    else if (fall_i)              held_d = 1'b1;
    else if (rearm_i && lk_i)     held_d = 1'b1;
    else if (release_i && lk_i)   held_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  assign hold_active_o = held_q | (mode_en_i & ~lk_i);

  // R5: no release happens while the link is unlocked
  p_no_release_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !lk_i && pwr_on_i) |=> held_q);
  // R6: a lock fall in hold-low mode re-arms the hold
  p_fall_rearms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_i && mode_en_i && pwr_on_i && !pwr_rise_i) |=> held_q);
  // R7: re-arm wins over a simultaneous release
  p_rearm_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_i && release_i && lk_i && mode_en_i && pwr_on_i && !pwr_rise_i) |=> held_q);
endmodule

// File: rtl/dser_out_mux.sv
module dser_out_mux
  import dser_out_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 3,
  parameter int OSC_W  = 3
) (
  input  logic              powered_i,
  input  logic              hold_active_i,
  input  logic              lk_i,
  input  logic              oss_high_i,
  input  logic [OSC_W-1:0]  osc_sel_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [CTRL_W-1:0] rx_ctrl_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ctrl_oe_o,
  output logic              clk_oe_o,
  output clk_src_e          clk_src_o,
  output logic [OSC_W-1:0]  osc_code_o
);
  always_comb begin
    data_o     = '0;
    data_oe_o  = 1'b0;
    ctrl_o     = '0;
    ctrl_oe_o  = 1'b0;
    clk_oe_o   = 1'b0;
    clk_src_o  = CLK_LOW;
    osc_code_o = '0;
    if (powered_i) begin
      if (hold_active_i) begin
        data_oe_o = 1'b1;
        ctrl_oe_o = 1'b1;
        clk_oe_o  = 1'b1;
      end else if (lk_i) begin
        data_o    = rx_data_i;
        ctrl_o    = rx_ctrl_i;
        data_oe_o = 1'b1;
        ctrl_oe_o = 1'b1;
        clk_oe_o  = 1'b1;
        clk_src_o = CLK_RECOV;
      end else begin
        if (oss_high_i) begin
          data_o    = '1;
          ctrl_o    = '1;
          data_oe_o = 1'b1;
          ctrl_oe_o = 1'b1;
          clk_oe_o  = 1'b1;
          clk_src_o = CLK_HIGH;
        end
        if (osc_sel_i != '0) begin
          clk_oe_o   = 1'b1;
          clk_src_o  = CLK_OSC;
          osc_code_o = osc_sel_i;
        end
      end
    end
  end
endmodule

// File: rtl/dser_out_ctrl.sv
module dser_out_ctrl
  import dser_out_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int CTRL_W      = 3,
  parameter int OSC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_i,
  input  logic              hold_strap_i,
  input  logic              lock_async_i,
  input  logic              oss_high_i,
  input  logic [OSC_W-1:0]  osc_sel_i,
  input  logic              hold_rearm_i,
  input  logic              hold_release_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [CTRL_W-1:0] rx_ctrl_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_data_oe_o,
  output logic [CTRL_W-1:0] out_ctrl_o,
  output logic              out_ctrl_oe_o,
  output logic              out_clk_oe_o,
  output logic [1:0]        out_clk_src_o,
  output logic [OSC_W-1:0]  osc_code_o,
  output logic              lock_o
);
  logic     lk, lk_fall;
  logic     powered, pwr_rise, mode_en;
  logic     hold_active;
  clk_src_e clk_src;

  dser_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock_i (lock_async_i),
    .lk_o   (lk),
    .fall_o (lk_fall)
  );

  dser_strap_cap u_strap (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_on_i  (pwr_on_i),
    .strap_i   (hold_strap_i),
    .powered_o (powered),
    .rise_o    (pwr_rise),
    .mode_en_o (mode_en)
  );

  dser_hold_latch u_hold (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_on_i      (pwr_on_i),
    .pwr_rise_i    (pwr_rise),
    .strap_i       (hold_strap_i),
    .mode_en_i     (mode_en),
    .lk_i          (lk),
    .fall_i        (lk_fall),
    .rearm_i       (hold_rearm_i),
    .release_i     (hold_release_i),
    .hold_active_o (hold_active)
  );

  dser_out_mux #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .OSC_W(OSC_W)) u_mux (
    .powered_i     (powered),
    .hold_active_i (hold_active),
    .lk_i          (lk),
    .oss_high_i    (oss_high_i),
    .osc_sel_i     (osc_sel_i),
    .rx_data_i     (rx_data_i),
    .rx_ctrl_i     (rx_ctrl_i),
    .data_o        (out_data_o),
    .data_oe_o     (out_data_oe_o),
    .ctrl_o        (out_ctrl_o),
    .ctrl_oe_o     (out_ctrl_oe_o),
    .clk_oe_o      (out_clk_oe_o),
    .clk_src_o     (clk_src),
    .osc_code_o    (osc_code_o)
  );

  assign out_clk_src_o = clk_src;
  assign lock_o        = powered & lk;

  // R1: powered down means every group floats
  p_pwrdn_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on_i |-> (!out_data_oe_o && !out_ctrl_oe_o && !out_clk_oe_o && !lock_o));
  // R3 / R9: hold-low mode while unlocked drives zeros whatever oss_high_i says
  p_hold_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && mode_en && !lk) |-> (out_data_oe_o && out_data_o == '0 &&
                                      out_ctrl_o == '0 && out_clk_src_o == 2'b10));
  // R10: oscillator select takes the clock when unlocked outside hold-low mode
  p_osc_clock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && !mode_en && !lk && osc_sel_i != '0) |->
      (out_clk_oe_o && out_clk_src_o == 2'b01 && osc_code_o == osc_sel_i));
endmodule

// File: tb/dser_out_ctrl_bench.sv
module dser_out_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int CW = 3;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_on, strap, lock_in, oss_high, rearm, release_p;
  logic [2:0] osc_sel;
  logic [DW-1:0] rx_data;
  logic [CW-1:0] rx_ctrl;
  logic [DW-1:0] o_data;
  logic o_data_oe, o_ctrl_oe, o_clk_oe, o_lock;
  logic [CW-1:0] o_ctrl;
  logic [1:0] o_src;
  logic [2:0] o_osc;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // bench-side model state
  bit m_pwr, m_mode, m_held, m_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  dser_out_ctrl u_dser_out_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_on_i(pwr_on), .hold_strap_i(strap),
    .lock_async_i(lock_in), .oss_high_i(oss_high), .osc_sel_i(osc_sel),
    .hold_rearm_i(rearm), .hold_release_i(release_p), .rx_data_i(rx_data),
    .rx_ctrl_i(rx_ctrl), .out_data_o(o_data), .out_data_oe_o(o_data_oe),
    .out_ctrl_o(o_ctrl), .out_ctrl_oe_o(o_ctrl_oe), .out_clk_oe_o(o_clk_oe),
    .out_clk_src_o(o_src), .osc_code_o(o_osc), .lock_o(o_lock));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_hold();
    return m_held || (m_mode && !m_lock);
  endfunction

  function automatic string exp_tag();
    if (!m_pwr) return "R1";
    if (exp_hold()) return "R3";
    if (m_lock) return "R12";
    return "R8";
  endfunction

  // compare every output against values derived from the requirements
  task automatic check_all(input string req);
    logic [DW-1:0] e_data = '0;
    logic [CW-1:0] e_ctrl = '0;
    logic e_doe = 0, e_coe = 0, e_kee = 0, e_lock = 0;
    logic [1:0] e_src = 2'b10;
    logic [2:0] e_osc = 3'b000;
    if (m_pwr) begin
      e_lock = m_lock;
      if (exp_hold()) begin
        e_doe = 1; e_coe = 1; e_kee = 1;
      end else if (m_lock) begin
        e_data = rx_data; e_ctrl = rx_ctrl; e_doe = 1; e_coe = 1; e_kee = 1; e_src = 2'b00;
      end else begin
        if (oss_high) begin
          e_data = '1; e_ctrl = '1; e_doe = 1; e_coe = 1; e_kee = 1; e_src = 2'b11;
        end
        if (osc_sel != 3'b000) begin
          e_kee = 1; e_src = 2'b01; e_osc = osc_sel;
        end
      end
    end
    chk(req, "data", 32'(o_data), 32'(e_data));
    chk(req, "data_oe", 32'(o_data_oe), 32'(e_doe));
    chk(req, "ctrl", 32'(o_ctrl), 32'(e_ctrl));
    chk(req, "ctrl_oe", 32'(o_ctrl_oe), 32'(e_coe));
    chk(req, "clk_oe", 32'(o_clk_oe), 32'(e_kee));
    chk(req, "clk_src", 32'(o_src), 32'(e_src));
    chk(req, "osc_code", 32'(o_osc), 32'(e_osc));
    chk(req, "lock", 32'(o_lock), 32'(e_lock));
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_up(input bit s);
    strap = s; pwr_on = 1; step(3);
    m_pwr = 1; m_mode = s; m_held = s;
  endtask

  task automatic power_down();
    pwr_on = 0; step(2);
    m_pwr = 0; m_mode = 0; m_held = 0;
  endtask

  task automatic set_lock(input bit v);
    lock_in = v; step(4);
    if (m_lock && !v && m_mode && m_pwr) m_held = 1;
    m_lock = v;
  endtask

  task automatic pulse(input bit rel, input bit arm);
    release_p = rel; rearm = arm; step(1);
    release_p = 0; rearm = 0; step(1);
    if (m_pwr && m_mode && m_lock) begin
      if (arm) m_held = 1;
      else if (rel) m_held = 0;
    end
  endtask

  // release pulse on the same edge the asynchronous lock drops
  task automatic release_with_drop();
    release_p = 1; lock_in = 0; step(1);
    release_p = 0; step(4);
    if (m_pwr && m_mode && m_lock) m_held = 1;
    m_lock = 0;
  endtask

  initial begin
    rst_n = 0; pwr_on = 0; strap = 0; lock_in = 0; oss_high = 0;
    rearm = 0; release_p = 0; osc_sel = 3'b000; rx_data = 24'h5A3C96; rx_ctrl = 3'b101;
    m_pwr = 0; m_mode = 0; m_held = 0; m_lock = 0;
    step(3);
    check_all("R1");
    rst_n = 1; step(2);
    check_all("R1");

    // R1: first cycle after power enable still floats
    strap = 1; pwr_on = 1; step(0);
    #1 chk("R1", "data_oe first cycle", 32'(o_data_oe), 32'd0);
    step(3); m_pwr = 1; m_mode = 1; m_held = 1;
    check_all("R3");

    // R11: lock_o appears after the second rising edge
    oss_high = 1;
    lock_in = 1; @(posedge clk); @(negedge clk);
    chk("R11", "lock after one edge", 32'(o_lock), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R11", "lock after two edges", 32'(o_lock), 32'd1);
    step(2); m_lock = 1;
    check_all("R4");     // held low after relock, oss ignored (R9)
    pulse(1, 0);
    check_all("R4");     // released: pass-through R12
    chk("R12", "data pass", 32'(o_data), 32'h5A3C96);

    // R2: strap change while powered has no effect
    strap = 0; step(3);
    set_lock(0);
    check_all("R2");
    chk("R2", "still held low data_oe", 32'(o_data_oe), 32'd1);

    // R5: release while unlocked is dropped
    pulse(1, 0);
    set_lock(1);
    check_all("R5");
    chk("R5", "src low after relock", 32'(o_src), 32'd2);

    // R4 release, then R7 manual re-arm, then both pulses together
    pulse(1, 0);
    check_all("R4");
    pulse(0, 1);
    check_all("R7");
    chk("R7", "rearm forces low", 32'(o_data), 32'd0);
    pulse(1, 0);
    pulse(1, 1);
    check_all("R7");
    chk("R7", "both pulses hold", 32'(o_src), 32'd2);

    // R6: release coinciding with lock drop, then relock stays held
    pulse(1, 0);
    check_all("R12");
    release_with_drop();
    set_lock(1);
    check_all("R6");
    chk("R6", "rearmed after fall", 32'(o_data_oe & (o_data == 0)), 32'd1);

    // R9: hold mode unlocked ignores oss and oscillator
    set_lock(0);
    oss_high = 0; osc_sel = 3'b110; step(1);
    check_all("R9");
    oss_high = 1; step(1);
    check_all("R9");

    // R8 / R10: no hold mode
    power_down();
    check_all("R1");
    power_up(0);
    osc_sel = 3'b000; oss_high = 0; step(1);
    check_all("R8");
    chk("R8", "float data_oe", 32'(o_data_oe), 32'd0);
    oss_high = 1; step(1);
    check_all("R8");
    chk("R10", "high clock src", 32'(o_src), 32'd3);
    for (int c = 5; c < 8; c++) begin
      osc_sel = 3'(c); step(1);
      check_all("R10");
      chk("R10", "osc code", 32'(o_osc), 32'(c));
    end
    set_lock(1);
    check_all("R10");
    chk("R10", "osc code when locked", 32'(o_osc), 32'd0);

    // constrained random mix
    void'($urandom(32'd20240611));
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom % 9);
      case (op)
        0: set_lock(!lock_in);
        1: pulse(1, 0);
        2: pulse(0, 1);
        3: pulse(1, 1);
        4: begin
          rx_data = DW'($urandom); rx_ctrl = CW'($urandom);
          oss_high = 1'($urandom); osc_sel = 3'($urandom); step(1);
        end
        5: if ($urandom % 4 == 0) begin
          power_down(); check_all("R1"); power_up(1'($urandom));
        end else step(1);
        6: begin strap = !strap; step(2); end
        7: if (lock_in) release_with_drop(); else set_lock(1);
        default: step(1);
      endcase
      check_all(exp_tag());
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule